// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block turns a 32-bit virtual address into a physical address. The upper 20 bits form the virtual page number and the lower 12 bits form the in-page offset. The lookup is combinational: every stored entry compares its page number and its 6-bit address-space tag against the request in parallel. Entries of different processes can therefore stay in the table together, and a context switch needs no flush.

The three most significant address bits choose the segment. Two segments are translated through the table: user space and mapped kernel space. The other two pass the address straight through as kernel physical space, one cacheable and one uncacheable. A mapped lookup ends in one of four outcomes: a hit, a miss, a protection fault or a modify fault. A miss or fault is reported to software, which loads the table through a one-cycle fill port that takes an index and a complete entry. A global flush input invalidates every entry.

Top module: `tlb_xlate`

## Requirements
- R1: After reset no entry is valid, so every requested lookup in a translated segment reports `miss_o`=1 and `hit_o`=0.
- R2: A fill with `fill_en_i`=1 writes the entry at `fill_idx_i` on that clock edge. A read lookup from the next cycle on, with the same page number and tag, gives `hit_o`=1 and `paddr_o` = {stored frame number, `vaddr_i[11:0]`}.
- R3: An entry matches only when both its page number and its 6-bit tag equal the request. The same page under another tag reports a miss.
- R4: Segment decode uses `vaddr_i[31:29]`. A leading 0 (0xx) or a leading 11 (11x) is translated. 100 is pass-through cacheable and 101 is pass-through uncacheable. A pass-through request gives `hit_o`=`miss_o`=0, `paddr_o` = `vaddr_i` with bits 31:29 cleared, and `cacheable_o` = !`vaddr_i[29]`. Translated segments report `cacheable_o`=1.
- R5: A store (`wr_i`=1) that matches an entry whose write-permit bit is 0 raises `prot_fault_o` instead of `hit_o`.
- R6: A store that matches a write-permitted entry whose dirty bit is 0 raises `mod_fault_o` instead of `hit_o`. Loads (`wr_i`=0) never fault.
- R7: `flush_i` clears every valid bit at the clock edge. A fill in the same cycle is dropped.
- R8: When several entries match, the lowest index supplies the frame number and `multi_hit_o` is 1.
- R9: An entry written with `fill_valid_i`=0 never matches.
- R10: `ref_o` shows the referenced bit of the matching entry on a mapped match.
- R11: With `req_i`=0, the outputs `hit_o`, `miss_o`, `prot_fault_o`, `mod_fault_o`, `multi_hit_o`, `ref_o`, `cacheable_o` and `paddr_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Lookup request |
| vaddr_i | input | 32 | Virtual address |
| asid_i | input | 6 | Address-space tag of the request |
| wr_i | input | 1 | Access is a store |
| paddr_o | output | 32 | Physical address |
| hit_o | output | 1 | Translation succeeded |
| miss_o | output | 1 | No matching entry in a translated segment |
| prot_fault_o | output | 1 | Store to a read-only page |
| mod_fault_o | output | 1 | Store to a clean page |
| multi_hit_o | output | 1 | More than one entry matched |
| ref_o | output | 1 | Referenced bit of the matching entry |
| cacheable_o | output | 1 | Access may be cached |
| flush_i | input | 1 | Invalidate all entries |
| fill_en_i | input | 1 | Write one entry |
| fill_idx_i | input | 6 | Entry index to write |
| fill_vpn_i | input | 20 | Virtual page number of the entry |
| fill_asid_i | input | 6 | Address-space tag of the entry |
| fill_pfn_i | input | 20 | Physical frame number of the entry |
| fill_valid_i | input | 1 | Valid bit of the entry |
| fill_dirty_i | input | 1 | Dirty bit of the entry |
| fill_ref_i | input | 1 | Referenced bit of the entry |
| fill_wr_ok_i | input | 1 | Write-permit bit of the entry |

## Verification
Because the lookup is combinational, a corrupted stored field appears at the ports in the same cycle as the lookup that selects the entry. A wrong frame number shows up in `paddr_o`. A wrong tag or page number turns a hit into a miss, or the reverse. A wrong dirty or write-permit bit swaps a hit for a fault. Two faults do not show as a wrong value at lookup time: a stuck valid bit and a fill that does not land. Both appear on the first lookup after the fill or flush edge. For that reason the bench fills all 64 entries with arithmetically distinct contents, then sweeps loads, stores and foreign-tag lookups over every index.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
  localparam int unsigned VA_W   = 32;
  localparam int unsigned OFF_W  = 12;
  localparam int unsigned VPN_W  = VA_W - OFF_W;
  localparam int unsigned PFN_W  = 20;
  localparam int unsigned ASID_W = 6;
  localparam int unsigned SEG_W  = 3;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [PFN_W-1:0]  pfn;
    logic              dirty;
    logic              refd;
    logic              wr_ok;
  } tlb_ent_t;
endpackage

// File: rtl/tlb_seg_dec.sv
`timescale 1ns/1ps
module tlb_seg_dec (
  input  logic [2:0] top_i,
  output logic       mapped_o,
  output logic       cacheable_o
);
  always_comb begin
    unique casez (top_i)
      3'b0??:  begin mapped_o = 1'b1; cacheable_o = 1'b1; end
      3'b100:  begin mapped_o = 1'b0; cacheable_o = 1'b1; end
      3'b101:  begin mapped_o = 1'b0; cacheable_o = 1'b0; end
      default: begin mapped_o = 1'b1; cacheable_o = 1'b1; end
    endcase
  end
endmodule

// File: rtl/tlb_ent_array.sv
`timescale 1ns/1ps
module tlb_ent_array
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                flush_i,
  input  logic                fill_en_i,
  input  logic [IDX_W-1:0]    fill_idx_i,
  input  logic                fill_valid_i,
  input  tlb_ent_t            fill_ent_i,
  input  logic [VPN_W-1:0]    look_vpn_i,
  input  logic [ASID_W-1:0]   look_asid_i,
  input  logic [IDX_W-1:0]    sel_idx_i,
  output logic [ENTRIES-1:0]  match_o,
  output tlb_ent_t            sel_ent_o
);
  logic [ENTRIES-1:0] valid_q;
  tlb_ent_t           ent_q [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        valid_q <= '0;
    else if (flush_i)   valid_q <= '0;
    else if (fill_en_i) valid_q[fill_idx_i] <= fill_valid_i;
  end

  // payload carries no reset; valid bit gates it
  always_ff @(posedge clk_i) begin
    if (fill_en_i && !flush_i) ent_q[fill_idx_i] <= fill_ent_i;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_o[g] = valid_q[g] && (ent_q[g].vpn == look_vpn_i)
                        && (ent_q[g].asid == look_asid_i);
  end

  assign sel_ent_o = ent_q[sel_idx_i];
endmodule

// File: rtl/tlb_prio_enc.sv
`timescale 1ns/1ps
module tlb_prio_enc #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] match_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               any_o,
  output logic               multi_o
);
  always_comb begin
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o   = |match_i;
  // clearing the lowest set bit leaves something iff two or more are set
  assign multi_o = |(match_i & (match_i - ENTRIES'(1)));
endmodule

// File: rtl/tlb_xlate.sv
`timescale 1ns/1ps
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [31:0]       vaddr_i,
  input  logic [5:0]        asid_i,
  input  logic              wr_i,
  output logic [31:0]       paddr_o,
  output logic              hit_o,
  output logic              miss_o,
  output logic              prot_fault_o,
  output logic              mod_fault_o,
  output logic              multi_hit_o,
  output logic              ref_o,
  output logic              cacheable_o,
  input  logic              flush_i,
  input  logic              fill_en_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [19:0]       fill_vpn_i,
  input  logic [5:0]        fill_asid_i,
  input  logic [19:0]       fill_pfn_i,
  input  logic              fill_valid_i,
  input  logic              fill_dirty_i,
  input  logic              fill_ref_i,
  input  logic              fill_wr_ok_i
);
  logic               seg_mapped, seg_cache;
  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0]   sel_idx;
  logic               any_m, multi_m, look;
  tlb_ent_t           fill_ent, sel_ent;

  assign fill_ent = '{vpn: fill_vpn_i, asid: fill_asid_i, pfn: fill_pfn_i,
                      dirty: fill_dirty_i, refd: fill_ref_i, wr_ok: fill_wr_ok_i};

  tlb_seg_dec i_seg (
    .top_i       (vaddr_i[VA_W-1 -: SEG_W]),
    .mapped_o    (seg_mapped),
    .cacheable_o (seg_cache)
  );

  tlb_ent_array #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_arr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush_i),
    .fill_en_i    (fill_en_i),
    .fill_idx_i   (fill_idx_i),
    .fill_valid_i (fill_valid_i),
    .fill_ent_i   (fill_ent),
    .look_vpn_i   (vaddr_i[VA_W-1:OFF_W]),
    .look_asid_i  (asid_i),
    .sel_idx_i    (sel_idx),
    .match_o      (match),
    .sel_ent_o    (sel_ent)
  );

  tlb_prio_enc #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_prio (
    .match_i (match),
    .idx_o   (sel_idx),
    .any_o   (any_m),
    .multi_o (multi_m)
  );

  assign look = req_i && seg_mapped;

  always_comb begin
    prot_fault_o = look && any_m && wr_i && !sel_ent.wr_ok;
    mod_fault_o  = look && any_m && wr_i && sel_ent.wr_ok && !sel_ent.dirty;
    hit_o        = look && any_m && !prot_fault_o && !mod_fault_o;
    miss_o       = look && !any_m;
    multi_hit_o  = look && multi_m;
    ref_o        = look && any_m && sel_ent.refd;
    cacheable_o  = req_i && seg_cache;
    if (req_i && !seg_mapped) paddr_o = {{SEG_W{1'b0}}, vaddr_i[VA_W-SEG_W-1:0]};
    else if (hit_o)           paddr_o = {sel_ent.pfn, vaddr_i[OFF_W-1:0]};
    else                      paddr_o = '0;
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
`timescale 1ns/1ps
module tlb_xlate_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic [31:0] vaddr_i,
  input logic        wr_i,
  input logic [31:0] paddr_o,
  input logic        hit_o,
  input logic        miss_o,
  input logic        prot_fault_o,
  input logic        mod_fault_o,
  input logic        multi_hit_o,
  input logic        ref_o,
  input logic        flush_i
);
  p_offset_keep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> paddr_o[11:0] == vaddr_i[11:0]);

  p_pass_through_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && vaddr_i[31:30] == 2'b10) |->
      (!hit_o && !miss_o && paddr_o == {3'b000, vaddr_i[28:0]}));

  p_one_outcome_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({hit_o, miss_o, prot_fault_o, mod_fault_o}) <= 1);

  p_load_no_fault_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |-> (!prot_fault_o && !mod_fault_o));

  p_flush_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(flush_i) && req_i && vaddr_i[31:29] != 3'b100 && vaddr_i[31:29] != 3'b101)
      |-> miss_o);

  p_multi_matched_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_hit_o |-> !miss_o);

  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> (!hit_o && !miss_o && !prot_fault_o && !mod_fault_o
                && !multi_hit_o && !ref_o && paddr_o == 32'h0));
endmodule

bind tlb_xlate tlb_xlate_chk i_chk (.*);

// File: tb/test_tlb_xlate.sv
`timescale 1ns/1ps
module test_tlb_xlate;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_i = 0, wr_i = 0, flush_i = 0, fill_en_i = 0;
  logic [31:0] vaddr_i = '0;
  logic [5:0]  asid_i = '0, fill_idx_i = '0, fill_asid_i = '0;
  logic [19:0] fill_vpn_i = '0, fill_pfn_i = '0;
  logic        fill_valid_i = 0, fill_dirty_i = 0, fill_ref_i = 0, fill_wr_ok_i = 0;
  logic [31:0] paddr_o;
  logic        hit_o, miss_o, prot_fault_o, mod_fault_o, multi_hit_o, ref_o, cacheable_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  tlb_xlate i_tlb_xlate (.*);

  function automatic logic [19:0] vpn_of(int i);
    return (i % 2 == 0) ? 20'(20'h00100 + i * 3) : 20'(20'hC0000 + i);
  endfunction
  function automatic logic [19:0] pfn_of(int i);
    return 20'h A5000 ^ 20'(i * 7);
  endfunction
  function automatic logic [5:0] asid_of(int i);
    return 6'(i) ^ 6'h15;
  endfunction
  function automatic logic wrok_of(int i);  return (i % 3) != 0;       endfunction
  function automatic logic dirty_of(int i); return ((i / 2) % 2) == 0; endfunction
  function automatic logic ref_of(int i);   return (i % 5) == 0;       endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill(input int idx, input logic [19:0] vpn, input logic [5:0] asid,
                      input logic [19:0] pfn, input logic v, input logic d,
                      input logic r, input logic w, input logic fl);
    @(negedge clk_i);
    fill_en_i = 1; fill_idx_i = 6'(idx); fill_vpn_i = vpn; fill_asid_i = asid;
    fill_pfn_i = pfn; fill_valid_i = v; fill_dirty_i = d; fill_ref_i = r;
    fill_wr_ok_i = w; flush_i = fl;
    @(negedge clk_i);
    fill_en_i = 0; flush_i = 0;
  endtask

  task automatic look(input logic [31:0] va, input logic [5:0] asid, input logic wr);
    @(negedge clk_i);
    req_i = 1; vaddr_i = va; asid_i = asid; wr_i = wr;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;

    look({vpn_of(0), 12'h123}, asid_of(0), 0);
    chk(miss_o && !hit_o, "R1 miss after reset", {miss_o, hit_o}, 2'b10);

    for (int i = 0; i < 64; i++)
      fill(i, vpn_of(i), asid_of(i), pfn_of(i), 1, dirty_of(i), ref_of(i), wrok_of(i), 0);

    for (int i = 0; i < 64; i++) begin
      logic [11:0] off = 12'(i * 37);
      look({vpn_of(i), off}, asid_of(i), 0);
      chk(hit_o && paddr_o == {pfn_of(i), off}, "R2 load hit", paddr_o, {pfn_of(i), off});
      chk(ref_o == ref_of(i), "R10 referenced bit", 32'(ref_o), 32'(ref_of(i)));
      chk(cacheable_o, "R4 mapped cacheable", 32'(cacheable_o), 1);
      look({vpn_of(i), off}, asid_of(i), 1);
      if (!wrok_of(i))
        chk(prot_fault_o && !hit_o && !mod_fault_o, "R5 store read-only",
            {prot_fault_o, mod_fault_o, hit_o}, 3'b100);
      else if (!dirty_of(i))
        chk(mod_fault_o && !hit_o && !prot_fault_o, "R6 store clean",
            {prot_fault_o, mod_fault_o, hit_o}, 3'b010);
      else
        chk(hit_o && !mod_fault_o && !prot_fault_o, "R6 store dirty writable",
            {prot_fault_o, mod_fault_o, hit_o}, 3'b001);
      look({vpn_of(i), off}, asid_of(i) ^ 6'h3F, 0);
      chk(miss_o && !hit_o, "R3 foreign tag misses", {miss_o, hit_o}, 2'b10);
    end

    for (int k = 0; k < 32; k++) begin
      logic [31:0] va = {2'b10, 1'(k % 2), 29'(k * 32'h00F1_2345)};
      look(va, 6'(k), 1'(k / 16));
      chk(!hit_o && !miss_o && paddr_o == {3'b000, va[28:0]} && cacheable_o == !va[29],
          "R4 pass-through", paddr_o, {3'b000, va[28:0]});
    end

    @(negedge clk_i);
    req_i = 0; vaddr_i = {vpn_of(2), 12'h0}; asid_i = asid_of(2); wr_i = 1;
    #1;
    chk(!hit_o && !miss_o && !prot_fault_o && !mod_fault_o && !multi_hit_o && !ref_o
        && !cacheable_o && paddr_o == 0, "R11 idle outputs", paddr_o, 0);

    fill(63, vpn_of(4), asid_of(4), 20'h12345, 1, 1, 0, 1, 0);
    look({vpn_of(4), 12'hABC}, asid_of(4), 0);
    chk(hit_o && multi_hit_o && paddr_o == {pfn_of(4), 12'hABC}, "R8 lowest index wins",
        paddr_o, {pfn_of(4), 12'hABC});

    fill(4, vpn_of(4), asid_of(4), pfn_of(4), 0, 1, 0, 1, 0);
    look({vpn_of(4), 12'hABC}, asid_of(4), 0);
    chk(hit_o && !multi_hit_o && paddr_o == {20'h12345, 12'hABC}, "R9 invalid entry ignored",
        paddr_o, {20'h12345, 12'hABC});

    fill(0, 20'h00777, 6'h2A, 20'h55555, 1, 1, 1, 1, 1);
    look({20'h00777, 12'h0}, 6'h2A, 0);
    chk(miss_o, "R7 fill during flush dropped", 32'(miss_o), 1);
    for (int i = 1; i < 64; i += 7) begin
      look({vpn_of(i), 12'h0}, asid_of(i), 0);
      chk(miss_o && !hit_o, "R7 flushed entry misses", {miss_o, hit_o}, 2'b10);
    end

    fill(9, 20'hE0001, 6'h01, 20'h00042, 1, 1, 0, 1, 0);
    look({20'hE0001, 12'hFFF}, 6'h01, 1);
    chk(hit_o && paddr_o == 32'h0004_2FFF, "R2 refill after flush", paddr_o, 32'h0004_2FFF);

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule